// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single pulse-width-modulated command into two gate-enable signals for a synchronous buck stage. One enable drives the upper (high-side) switch in phase with the command. The other drives the lower (low-side) switch in antiphase. Whenever the command changes, the sequencer first turns the conducting switch off. It then waits out a dead time before it turns the other switch on, so the two switches never conduct together.

The dead time after the high-side switch turns off adapts to feedback from the switch node:

- If the node was seen high and then drops below the low-level comparator threshold, the low side turns on at once.
- If the node was never seen high, the low side turns on after a fixed fallback count.
- If the node stays up, a separate, longer timeout forces the low side on. This case covers reverse inductor current.

Before the high-side switch turns on, the sequencer waits for a comparator that reports the low-side gate has discharged, and then adds a short fixed delay. An active-low hold-off input blanks both enables straight away.

All five inputs are asynchronous. Each passes through a two-flop synchronizer, and every delay is a parameter counted in clock cycles. A change on any input therefore reaches the state register three rising edges after it is applied.

Top module: `dt_gate_seq`

## Requirements
- R1: While reset is asserted, and while the hold-off input is low, both hsOn and lsOn are 0.
- R2: Driving holdOffN low forces hsOn and lsOn to 0 in the same cycle, before any clock edge, whatever the other inputs do. Once holdOffN returns high with pwmIn low, lsOn turns on again.
- R3: In steady state with holdOffN high, pwmIn=1 gives hsOn=1, lsOn=0, and pwmIn=0 gives hsOn=0, lsOn=1.
- R4: After a pwmIn fall, suppose swHighIn was 1 during the high-side on-time. Then lsOn rises exactly 3 cycles after swLowIn is driven to 1, provided this comes before the timeout.
- R5: If swHighIn stayed 0 throughout the high-side on-time, lsOn rises FIX_CYC cycles after hsOn falls. The default is 15.
- R6: If the switch node was seen high but swLowIn never rises, lsOn rises TMO_CYC cycles after hsOn falls. The default is 19.
- R7: After a pwmIn rise, hsOn stays 0 while gateLowIn is 0. hsOn rises exactly GATE_DLY_CYC+3 cycles after gateLowIn is driven to 1. The default is 3, giving 6 cycles.
- R8: hsOn and lsOn are never both 1 in any cycle.
- R9: Suppose pwmIn returns high while the low-side turn-on is still pending. Then that turn-on is cancelled: lsOn stays 0 and hsOn is re-enabled through the gate-low path. A reversal in the same cycle as the dead-time expiry also wins over the expiry.
- R10: hsOn falls exactly 3 cycles after a falling edge on pwmIn. lsOn falls exactly 3 cycles after a rising edge on pwmIn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmIn | input | 1 | PWM command, 1 = high side conducts |
| holdOffN | input | 1 | Active-low output disable |
| swHighIn | input | 1 | Switch node seen high comparator |
| swLowIn | input | 1 | Switch node below low threshold comparator |
| gateLowIn | input | 1 | Low-side gate discharged comparator |
| hsOn | output | 1 | High-side gate enable |
| lsOn | output | 1 | Low-side gate enable |

## Verification
Two functions can act in the same cycle. A PWM reversal can meet the expiry of a dead-time count or the arrival of a switch-node event, and a hold-off can land in the middle of either transition. The directed cases reverse PWM shortly after the high side drops. The random phase toggles PWM, the comparators and the hold-off on independent sparse schedules, which drives reversals onto expiry cycles. Every cycle is judged for overlap of the two enables and for blanking under hold-off. Afterwards a directed settle confirms that the sequencer still reaches the correct steady state.

// File: rtl/dt_seq_pkg.sv
package dt_seq_pkg;
  typedef enum logic [2:0] {
    S_OFF,
    S_HS,
    S_HL_WAIT,
    S_LS,
    S_LH_GATE,
    S_LH_DLY
  } seqState_t;

  typedef struct packed {
    logic clr;
    logic run;
  } tmrCmd_t;
endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end
endmodule

// File: rtl/dt_timer.sv
module dt_timer
  import dt_seq_pkg::*;
#(
  parameter int FIX_CYC      = 15,
  parameter int TMO_CYC      = 19,
  parameter int GATE_DLY_CYC = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  tmrCmd_t cmd,
  output logic    hitFix,
  output logic    hitTmo,
  output logic    hitGate
);
  localparam int MAXA = (FIX_CYC > TMO_CYC) ? FIX_CYC : TMO_CYC;
  localparam int MAXC = (MAXA > GATE_DLY_CYC) ? MAXA : GATE_DLY_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (cmd.clr) begin
      count <= '0;
    end else if (cmd.run && (count != CW'(MAXC))) begin
      count <= count + 1'b1;
    end
  end

  assign hitFix  = (count == CW'(FIX_CYC - 1));
  assign hitTmo  = (count == CW'(TMO_CYC - 1));
  assign hitGate = (count == CW'(GATE_DLY_CYC - 1));

  a_r6_clear_restarts: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> (count == '0));
endmodule

// File: rtl/dt_ctrl.sv
module dt_ctrl
  import dt_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pwmS,
  input  logic      holdOffS,
  input  logic      swHighS,
  input  logic      swLowS,
  input  logic      gateLowS,
  input  logic      hitFix,
  input  logic      hitTmo,
  input  logic      hitGate,
  output seqState_t state,
  output tmrCmd_t   cmd
);
  seqState_t nxt;
  logic      seenQ;

  always_comb begin
    nxt     = state;
    cmd.clr = 1'b0;
    cmd.run = 1'b1;
    if (!holdOffS) begin
      nxt = S_OFF;
    end else begin
      case (state)
        S_OFF:     nxt = pwmS ? S_LH_GATE : S_LS;
        S_HS: begin
          if (!pwmS) begin
            nxt     = S_HL_WAIT;
            cmd.clr = 1'b1;
          end
        end
        S_HL_WAIT: begin
          if (pwmS)                                                  nxt = S_LH_GATE;
          else if ((seenQ && swLowS) || (!seenQ && hitFix) || hitTmo) nxt = S_LS;
        end
        S_LS:      if (pwmS) nxt = S_LH_GATE;
        S_LH_GATE: begin
          if (!pwmS) begin
            nxt = S_LS;
          end else if (gateLowS) begin
            nxt     = S_LH_DLY;
            cmd.clr = 1'b1;
          end
        end
        S_LH_DLY: begin
          if (!pwmS)        nxt = S_LS;
          else if (hitGate) nxt = S_HS;
        end
        default:   nxt = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_OFF;
      seenQ <= 1'b0;
    end else begin
      state <= nxt;
      if ((nxt == S_HS) && (state != S_HS))
        seenQ <= 1'b0;
      else if (((state == S_HS) || (state == S_HL_WAIT)) && swHighS)
        seenQ <= 1'b1;
    end
  end

  logic hsState;
  logic lsState;
  assign hsState = (state == S_HS);
  assign lsState = (state == S_LS);

  a_r2_holdoff_to_off: assert property (@(posedge clk) disable iff (!rstN)
    !holdOffS |=> (state == S_OFF));
  a_r3_ls_not_from_hs: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsState) |-> ($past(state) != S_HS));
  a_r7_hs_after_delay: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsState) |-> ($past(state) == S_LH_DLY));
  a_r6_timeout_leaves: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_HL_WAIT) && hitTmo) |=> (state != S_HL_WAIT));
  a_r9_reversal_wins: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_HL_WAIT) && pwmS && holdOffS) |=> (state == S_LH_GATE));
endmodule

// File: rtl/dt_gate_seq.sv
module dt_gate_seq
  import dt_seq_pkg::*;
#(
  parameter int FIX_CYC      = 15,
  parameter int TMO_CYC      = 19,
  parameter int GATE_DLY_CYC = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmIn,
  input  logic holdOffN,
  input  logic swHighIn,
  input  logic swLowIn,
  input  logic gateLowIn,
  output logic hsOn,
  output logic lsOn
);
  localparam int NIN = 5;

  logic [NIN-1:0] rawIn;
  logic [NIN-1:0] syncIn;
  seqState_t      state;
  tmrCmd_t        cmd;
  logic           hitFix;
  logic           hitTmo;
  logic           hitGate;

  assign rawIn = {gateLowIn, swLowIn, swHighIn, holdOffN, pwmIn};

  dt_sync #(.W(NIN)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncIn)
  );

  dt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .pwmS(syncIn[0]), .holdOffS(syncIn[1]), .swHighS(syncIn[2]),
    .swLowS(syncIn[3]), .gateLowS(syncIn[4]),
    .hitFix(hitFix), .hitTmo(hitTmo), .hitGate(hitGate),
    .state(state), .cmd(cmd)
  );

  dt_timer #(.FIX_CYC(FIX_CYC), .TMO_CYC(TMO_CYC), .GATE_DLY_CYC(GATE_DLY_CYC)) u_timer (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .hitFix(hitFix), .hitTmo(hitTmo), .hitGate(hitGate)
  );

  assign hsOn = (state == S_HS) && holdOffN;
  assign lsOn = (state == S_LS) && holdOffN;

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(hsOn && lsOn));
endmodule

// File: tb/sim_dt_gate_seq.sv
module sim_dt_gate_seq;
  localparam int FIX  = 15;
  localparam int TMO  = 19;
  localparam int GDLY = 3;

  logic clk = 1'b0;
  logic rstN, pwmIn, holdOffN, swHighIn, swLowIn, gateLowIn;
  logic hsOn, lsOn;
  int   vectors = 0;
  int   fails = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  dt_gate_seq #(.FIX_CYC(FIX), .TMO_CYC(TMO), .GATE_DLY_CYC(GATE_DLY_CYC_DEF)) u0 (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .holdOffN(holdOffN),
    .swHighIn(swHighIn), .swLowIn(swLowIn), .gateLowIn(gateLowIn),
    .hsOn(hsOn), .lsOn(lsOn)
  );
  localparam int GATE_DLY_CYC_DEF = GDLY;

  function automatic bit legalOut(logic h, logic l, logic off);
    if (h && l) return 1'b0;
    if (!off && (h || l)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitOut(input bit useLs, input logic target, input int maxc, output int n);
    n = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if ((useLs ? lsOn : hsOn) == target) begin
        n = i;
        return;
      end
    end
  endtask

  task automatic goHigh(input string tag);
    int n;
    pwmIn = 1'b1;
    gateLowIn = 1'b0;
    waitOut(1'b1, 1'b0, 20, n);
    check(n == 3, "R10 ls fall latency", n, 3);
    repeat (4) @(negedge clk);
    check(hsOn == 1'b0, "R7 hs held while gate high", hsOn, 0);
    gateLowIn = 1'b1;
    waitOut(1'b0, 1'b1, 40, n);
    check(n == GDLY + 3, tag, n, GDLY + 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit lsEver;
    void'($urandom(32'd2024));
    rstN = 1'b0; pwmIn = 1'b0; holdOffN = 1'b0;
    swHighIn = 1'b0; swLowIn = 1'b0; gateLowIn = 1'b0;
    repeat (3) @(negedge clk);
    check(!hsOn && !lsOn, "R1 reset outputs", {hsOn, lsOn}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!hsOn && !lsOn, "R1 holdoff outputs", {hsOn, lsOn}, 0);
    holdOffN = 1'b1;
    waitOut(1'b1, 1'b1, 20, n);
    repeat (3) @(negedge clk);
    check(lsOn && !hsOn, "R3 steady low", {hsOn, lsOn}, 1);

    // R7 and R10: rising transition
    goHigh("R7 hs after gate low");
    repeat (3) @(negedge clk);
    check(hsOn && !lsOn, "R3 steady high", {hsOn, lsOn}, 2);

    // R4: node seen high, then falls
    swHighIn = 1'b1;
    repeat (5) @(negedge clk);
    pwmIn = 1'b0;
    waitOut(1'b0, 1'b0, 20, n);
    check(n == 3, "R10 hs fall latency", n, 3);
    swHighIn = 1'b0;
    repeat (4) @(negedge clk);
    check(lsOn == 1'b0, "R4 ls waits for node", lsOn, 0);
    swLowIn = 1'b1;
    waitOut(1'b1, 1'b1, 40, n);
    check(n == 3, "R4 ls after node low", n, 3);

    // R5: node never seen high
    goHigh("R7 hs after gate low 2");
    repeat (5) @(negedge clk);
    pwmIn = 1'b0;
    waitOut(1'b0, 1'b0, 20, n);
    waitOut(1'b1, 1'b1, 60, n);
    check(n == FIX, "R5 fixed fallback", n, FIX);

    // R6: node stays high
    goHigh("R7 hs after gate low 3");
    swLowIn = 1'b0;
    swHighIn = 1'b1;
    repeat (5) @(negedge clk);
    pwmIn = 1'b0;
    waitOut(1'b0, 1'b0, 20, n);
    waitOut(1'b1, 1'b1, 60, n);
    check(n == TMO, "R6 timeout", n, TMO);
    swHighIn = 1'b0;
    swLowIn = 1'b1;

    // R9: reversal during pending low-side turn-on
    goHigh("R7 hs after gate low 4");
    swHighIn = 1'b1;
    swLowIn = 1'b0;
    repeat (5) @(negedge clk);
    pwmIn = 1'b0;
    waitOut(1'b0, 1'b0, 20, n);
    repeat (2) @(negedge clk);
    pwmIn = 1'b1;
    lsEver = 1'b0;
    for (int i = 0; i < TMO + 10; i++) begin
      @(negedge clk);
      if (lsOn) lsEver = 1'b1;
    end
    check(!lsEver, "R9 ls cancelled", lsEver, 0);
    check(hsOn == 1'b1, "R9 hs restored", hsOn, 1);

    // R2: hold-off acts at once
    @(negedge clk);
    holdOffN = 1'b0;
    #1;
    check(!hsOn && !lsOn, "R2 immediate blank", {hsOn, lsOn}, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pwmIn = ~pwmIn;
      check(!hsOn && !lsOn, "R2 held blank", {hsOn, lsOn}, 0);
    end
    pwmIn = 1'b0;
    swHighIn = 1'b0;
    @(negedge clk);
    holdOffN = 1'b1;
    waitOut(1'b1, 1'b1, 20, n);
    check(lsOn == 1'b1, "R2 resume low side", lsOn, 1);
    @(negedge clk);
    holdOffN = 1'b0;
    #1;
    check(!lsOn, "R2 blank low side", lsOn, 0);
    @(negedge clk);
    holdOffN = 1'b1;

    // Random phase: R8 and R2 every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (($urandom % 12) == 0) pwmIn = ~pwmIn;
      if (($urandom % 7) == 0)  swHighIn = $urandom % 2;
      if (($urandom % 7) == 0)  swLowIn = $urandom % 2;
      if (($urandom % 5) == 0)  gateLowIn = $urandom % 2;
      if (($urandom % 40) == 0) holdOffN = ~holdOffN;
      #1;
      if (!legalOut(hsOn, lsOn, holdOffN))
        check(1'b0, "R8 R2 random legality", {hsOn, lsOn, holdOffN}, 1);
      else
        vectors++;
    end

    holdOffN = 1'b1;
    pwmIn = 1'b1;
    gateLowIn = 1'b1;
    repeat (40) @(negedge clk);
    check(hsOn && !lsOn, "R3 settle high after random", {hsOn, lsOn}, 2);
    pwmIn = 1'b0;
    swHighIn = 1'b0;
    repeat (40) @(negedge clk);
    check(lsOn && !hsOn, "R3 settle low after random", {hsOn, lsOn}, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule